// File: doc/BRIEF.md
# Half-Duplex Bus Transceiver Control Logic

This block is a cycle-based digital model of the logic side of an isolated differential bus transceiver. It decides, from a transmit bit, an active-high driver enable, an active-low receiver enable, two supply-good flags and a die-temperature code, whether the differential driver pair is driven and at what levels. It also decides whether the receive pin is driven and with which value. The line itself is represented by a signed differential-voltage sample in millivolts and a flag that marks the inputs as open.

The receiver uses a fail-safe threshold placed entirely on the negative side. Any differential voltage at or above -30 mV reads as a logic one, so an idle line that has decayed to 0 V, a shorted line or an open line all read high without bias resistors. Any voltage at or below -200 mV reads as a logic zero. Between those limits the result is uncertain. The model reports that band on its own status output and keeps the last definite receive value.

A registered thermal-shutdown flag overrides the driver enable. It sets at 150 °C and clears only after the temperature falls back to 140 °C.

Top module: `bus_xcvr_ctrl`

## Requirements
- R1: With drvEn=1, both supply flags high and no thermal shutdown, drvPosOe=drvNegOe=1, drvPos equals txBit and drvNeg equals its complement.
- R2: With drvEn=0, drvPosOe=drvNegOe=0 and drvPos=drvNeg=0 for either txBit.
- R3: With busPwrOk=0, drvPosOe=drvNegOe=0 whatever drvEn and txBit.
- R4: With rcvEnN=1, rxOe=0, rxUndef=0 and rxBit=1.
- R5: With the receiver enabled, both supplies good and lineOpen=0, diffMv >= -30 gives rxBit=1 and diffMv <= -200 gives rxBit=0, with rxOe=1 and rxUndef=0.
- R6: With the receiver enabled, both supplies good and lineOpen=0, -200 < diffMv < -30 gives rxUndef=1, rxOe=1, and rxBit equal to the last definite value driven with rxOe=1 (1 if none since reset).
- R7: With the receiver enabled, both supplies good and lineOpen=1, rxBit=1, rxOe=1 and rxUndef=0 for any diffMv.
- R8: At each rising clock edge the shutdown state sets if dieTemp >= 150, clears if dieTemp <= 140, and otherwise holds. While it is set, drvPosOe=drvNegOe=0.
- R9: With busPwrOk=0, logicPwrOk=1 and rcvEnN=0, rxOe=1, rxBit=1 and rxUndef=0.
- R10: With logicPwrOk=0, drvPosOe=drvNegOe=0, rxOe=0 and rxUndef=0.
- R11: Reset leaves the shutdown state clear and the held receive value at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txBit | input | 1 | Bit to transmit |
| drvEn | input | 1 | Driver enable, active high |
| rcvEnN | input | 1 | Receiver enable, active low |
| diffMv | input | MV_W | Signed differential line voltage in mV |
| lineOpen | input | 1 | Receiver inputs open |
| dieTemp | input | TEMP_W | Die temperature in °C, unsigned |
| logicPwrOk | input | 1 | Logic-side supply good |
| busPwrOk | input | 1 | Bus-side supply good |
| drvPos | output | 1 | Noninverting driver level |
| drvNeg | output | 1 | Inverting driver level |
| drvPosOe | output | 1 | Noninverting driver output enable |
| drvNegOe | output | 1 | Inverting driver output enable |
| rxBit | output | 1 | Receive output level |
| rxOe | output | 1 | Receive output enable |
| rxUndef | output | 1 | Differential input in the uncertain band |

## Verification
The driver path is tried with every combination of transmit bit, driver enable and the two supply flags. This shows that each gate alone can switch the pair off and that the pair is complementary when it is on. The receiver is swept one millivolt at a time from -400 to +400 mV. That sweep places both threshold edges exactly, and walking down through the uncertain band from each side shows that the held value follows the side last visited. Open-line, receiver-disabled and supply-loss cases are repeated over the same voltages. This shows that they mask the threshold logic. A temperature ramp up to 170 °C and back down separates the set point from the clear point and exposes the hysteresis window between them.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic drvOn;
    logic rxOn;
    logic rxForceHigh;
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int HOT_C  = 150,
  parameter int COOL_C = 140
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drvEn,
  input  logic              rcvEnN,
  input  logic [TEMP_W-1:0] dieTemp,
  input  logic              logicPwrOk,
  input  logic              busPwrOk,
  output xcvrStrobe_t       strobe
);
  localparam logic [TEMP_W-1:0] HOT_LIM  = TEMP_W'(HOT_C);
  localparam logic [TEMP_W-1:0] COOL_LIM = TEMP_W'(COOL_C);

  logic hotFlag;
  logic tooHot;
  logic cooled;

  assign tooHot = (dieTemp >= HOT_LIM);
  assign cooled = (dieTemp <= COOL_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hotFlag <= 1'b0;
    end else if (tooHot) begin
      hotFlag <= 1'b1;
    end else if (cooled) begin
      hotFlag <= 1'b0;
    end
  end

  always_comb begin
    strobe.drvOn       = drvEn & logicPwrOk & busPwrOk & ~hotFlag;
    strobe.rxOn        = ~rcvEnN & logicPwrOk;
    strobe.rxForceHigh = ~busPwrOk;
  end

  // R8: hot sample sets the flag at the next edge
  a_r8_trip: assert property (@(posedge clk) disable iff (!rstN)
    (dieTemp >= HOT_LIM) |=> hotFlag);
  // R8: cool sample clears the flag at the next edge
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (dieTemp <= COOL_LIM) |=> !hotFlag);
  // R8: hysteresis window keeps the state
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dieTemp > COOL_LIM && dieTemp < HOT_LIM) |=> (hotFlag == $past(hotFlag)));
  // R8: a set flag keeps the driver off
  a_r8_gate: assert property (@(posedge clk) disable iff (!rstN)
    hotFlag |-> !strobe.drvOn);
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int MV_W  = 16,
  parameter int HI_MV = -30,
  parameter int LO_MV = -200
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xcvrStrobe_t            strobe,
  input  logic                   txBit,
  input  logic signed [MV_W-1:0] diffMv,
  input  logic                   lineOpen,
  output logic [1:0]             drvVal,
  output logic [1:0]             drvOe,
  output logic                   rxBit,
  output logic                   rxOe,
  output logic                   rxUndef
);
  localparam logic signed [MV_W-1:0] HI_LIM = MV_W'(HI_MV);
  localparam logic signed [MV_W-1:0] LO_LIM = MV_W'(LO_MV);

  // pin 0 noninverting, pin 1 inverting
  for (genvar pin = 0; pin < 2; pin++) begin : g_pin
    localparam logic FLIP = (pin == 1);
    assign drvOe[pin]  = strobe.drvOn;
    assign drvVal[pin] = strobe.drvOn & (txBit ^ FLIP);
  end

  logic heldBit;

  always_comb begin
    rxOe    = strobe.rxOn;
    rxUndef = 1'b0;
    rxBit   = 1'b1;
    if (strobe.rxOn) begin
      if (strobe.rxForceHigh || lineOpen) begin
        rxBit = 1'b1;
      end else if (diffMv >= HI_LIM) begin
        rxBit = 1'b1;
      end else if (diffMv <= LO_LIM) begin
        rxBit = 1'b0;
      end else begin
        rxUndef = 1'b1;
        rxBit   = heldBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBit <= 1'b1;
    end else if (rxOe && !rxUndef) begin
      heldBit <= rxBit;
    end
  end

  // R1: an enabled pair is complementary
  a_r1_complement: assert property (@(posedge clk) disable iff (!rstN)
    (drvOe == 2'b11) |-> (drvVal[0] != drvVal[1]));
  // R4: the band flag never shows on a tristated receiver
  a_r4_flag_needs_oe: assert property (@(posedge clk) disable iff (!rstN)
    rxUndef |-> rxOe);
  // R7: an open line never reports the band
  a_r7_open_high: assert property (@(posedge clk) disable iff (!rstN)
    (rxOe && lineOpen) |-> (rxBit && !rxUndef));
endmodule

// File: rtl/bus_xcvr_ctrl.sv
module bus_xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int MV_W   = 16,
  parameter int TEMP_W = 8,
  parameter int HI_MV  = -30,
  parameter int LO_MV  = -200,
  parameter int HOT_C  = 150,
  parameter int COOL_C = 140
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   txBit,
  input  logic                   drvEn,
  input  logic                   rcvEnN,
  input  logic signed [MV_W-1:0] diffMv,
  input  logic                   lineOpen,
  input  logic [TEMP_W-1:0]      dieTemp,
  input  logic                   logicPwrOk,
  input  logic                   busPwrOk,
  output logic                   drvPos,
  output logic                   drvNeg,
  output logic                   drvPosOe,
  output logic                   drvNegOe,
  output logic                   rxBit,
  output logic                   rxOe,
  output logic                   rxUndef
);
  xcvrStrobe_t strobe;
  logic [1:0]  drvVal;
  logic [1:0]  drvOe;

  xcvr_ctrl #(.TEMP_W(TEMP_W), .HOT_C(HOT_C), .COOL_C(COOL_C)) uCtrl (
    .clk(clk), .rstN(rstN), .drvEn(drvEn), .rcvEnN(rcvEnN),
    .dieTemp(dieTemp), .logicPwrOk(logicPwrOk), .busPwrOk(busPwrOk),
    .strobe(strobe)
  );

  xcvr_datapath #(.MV_W(MV_W), .HI_MV(HI_MV), .LO_MV(LO_MV)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txBit(txBit),
    .diffMv(diffMv), .lineOpen(lineOpen), .drvVal(drvVal), .drvOe(drvOe),
    .rxBit(rxBit), .rxOe(rxOe), .rxUndef(rxUndef)
  );

  assign drvPos   = drvVal[0];
  assign drvNeg   = drvVal[1];
  assign drvPosOe = drvOe[0];
  assign drvNegOe = drvOe[1];

  // R2: disabled driver is off
  a_r2_drv_off: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |-> (!drvPosOe && !drvNegOe));
  // R3: no bus supply, no drive
  a_r3_bus_loss: assert property (@(posedge clk) disable iff (!rstN)
    !busPwrOk |-> (!drvPosOe && !drvNegOe));
  // R4: receiver disabled is tristated
  a_r4_rx_off: assert property (@(posedge clk) disable iff (!rstN)
    rcvEnN |-> (!rxOe && !rxUndef));
  // R6: band keeps the previous definite value
  a_r6_band_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxUndef && $past(rstN) && $past(rxOe && !rxUndef)) |-> (rxBit == $past(rxBit)));
  // R9: bus supply lost with receiver on reads high
  a_r9_bus_loss_high: assert property (@(posedge clk) disable iff (!rstN)
    (!busPwrOk && logicPwrOk && !rcvEnN) |-> (rxOe && rxBit && !rxUndef));
  // R10: logic supply lost tristates everything
  a_r10_logic_loss: assert property (@(posedge clk) disable iff (!rstN)
    !logicPwrOk |-> (!drvPosOe && !drvNegOe && !rxOe));
endmodule

// File: tb/tb_bus_xcvr_ctrl.sv
module tb_bus_xcvr_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txBit = 1'b0, drvEn = 1'b0, rcvEnN = 1'b1, lineOpen = 1'b0;
  logic signed [15:0] diffMv = '0;
  logic [7:0] dieTemp = 8'd25;
  logic logicPwrOk = 1'b1, busPwrOk = 1'b1;
  logic drvPos, drvNeg, drvPosOe, drvNegOe, rxBit, rxOe, rxUndef;

  int errCnt = 0;
  int chkCnt = 0;
  logic expHot = 1'b0;
  logic expHeld = 1'b1;

  always #4 clk = ~clk;

  bus_xcvr_ctrl dut (
    .clk(clk), .rstN(rstN), .txBit(txBit), .drvEn(drvEn), .rcvEnN(rcvEnN),
    .diffMv(diffMv), .lineOpen(lineOpen), .dieTemp(dieTemp),
    .logicPwrOk(logicPwrOk), .busPwrOk(busPwrOk),
    .drvPos(drvPos), .drvNeg(drvNeg), .drvPosOe(drvPosOe), .drvNegOe(drvNegOe),
    .rxBit(rxBit), .rxOe(rxOe), .rxUndef(rxUndef)
  );

  // expected outputs {drvPos,drvNeg,drvPosOe,drvNegOe,rxBit,rxOe,rxUndef}
  function automatic logic [6:0] expect_out();
    logic on, rOe, rB, rU;
    on  = drvEn && logicPwrOk && busPwrOk && !expHot;
    rOe = !rcvEnN && logicPwrOk;
    rB  = 1'b1;
    rU  = 1'b0;
    if (rOe && busPwrOk && !lineOpen) begin
      if (int'(diffMv) >= -30) rB = 1'b1;
      else if (int'(diffMv) <= -200) rB = 1'b0;
      else begin rU = 1'b1; rB = expHeld; end
    end
    return {on && txBit, on && !txBit, on, on, rB, rOe, rU};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expHot  <= 1'b0;
      expHeld <= 1'b1;
    end else begin
      logic [6:0] e;
      e = expect_out();
      if (dieTemp >= 8'd150) expHot <= 1'b1;
      else if (dieTemp <= 8'd140) expHot <= 1'b0;
      if (e[1] && !e[0]) expHeld <= e[2];
    end
  end

  task automatic check(input string tag);
    logic [6:0] act, exp;
    act = {drvPos, drvNeg, drvPosOe, drvNegOe, rxBit, rxOe, rxUndef};
    exp = expect_out();
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: outputs actual=%b expected=%b (diff=%0d temp=%0d)",
               tag, act, exp, diffMv, dieTemp);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    #1;
    check(tag);
  endtask

  task automatic set_rx(input int mv, input string tag);
    @(negedge clk);
    diffMv = 16'(mv);
    #1;
    check(tag);
  endtask

  bit finished = 0;

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state; temp inside window keeps drivers on, band reads held 1
    drvEn = 1'b1; txBit = 1'b1; rcvEnN = 1'b0; dieTemp = 8'd145; diffMv = -16'sd100;
    #1;
    chkCnt++;
    if (!(drvPosOe && rxBit && rxUndef)) begin
      errCnt++;
      $display("FAIL R11: {oe,rx,undef} actual=%b expected=111", {drvPosOe, rxBit, rxUndef});
    end
    step("R11");
    dieTemp = 8'd25;

    // R1 R2 R3 R10: driver sweep
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {txBit, drvEn, logicPwrOk, busPwrOk} = 4'(i);
      #1;
      if (!drvEn) check("R2");
      else if (!busPwrOk) check("R3");
      else if (!logicPwrOk) check("R10");
      else check("R1");
    end
    logicPwrOk = 1'b1; busPwrOk = 1'b1;

    // R5 R6: rising sweep then falling sweep
    rcvEnN = 1'b0; lineOpen = 1'b0;
    for (int mv = -400; mv <= 400; mv++) set_rx(mv, (mv > -200 && mv < -30) ? "R6" : "R5");
    for (int mv = 400; mv >= -400; mv--) set_rx(mv, (mv > -200 && mv < -30) ? "R6" : "R5");
    // R6: enter band from above
    set_rx(0, "R5");
    set_rx(-100, "R6");
    set_rx(-150, "R6");

    // R7: open line
    lineOpen = 1'b1;
    for (int mv = -400; mv <= 400; mv += 10) set_rx(mv, "R7");
    lineOpen = 1'b0;

    // R4: receiver disabled
    rcvEnN = 1'b1;
    for (int mv = -400; mv <= 400; mv += 10) set_rx(mv, "R4");
    rcvEnN = 1'b0;

    // R9: bus supply lost with receiver on
    busPwrOk = 1'b0;
    for (int mv = -400; mv <= 400; mv += 10) set_rx(mv, "R9");
    busPwrOk = 1'b1;

    // R10: logic supply lost
    logicPwrOk = 1'b0;
    for (int mv = -400; mv <= 400; mv += 10) set_rx(mv, "R10");
    logicPwrOk = 1'b1;

    // R8: thermal ramp up and down, one step per cycle
    diffMv = 16'sd100; drvEn = 1'b1; txBit = 1'b0;
    for (int t = 100; t <= 170; t++) begin
      @(negedge clk); dieTemp = 8'(t); #1; check("R8");
    end
    for (int t = 170; t >= 100; t--) begin
      @(negedge clk); dieTemp = 8'(t); #1; check("R8");
    end
    // R8: hover inside window after trip
    dieTemp = 8'd150; step("R8"); step("R8");
    dieTemp = 8'd145; step("R8"); step("R8");
    dieTemp = 8'd140; step("R8"); step("R8");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule